// File: doc/BRIEF.md
# Fixed-Point Accumulator Datapath

This block is the arithmetic core of a 16-bit fixed-point signal processor. A 32-bit accumulator is fed by a 32-bit two's-complement adder and bitwise unit. Operands reach the ALU through a programmable left shifter of 0 to 16 places, which sign-extends or zero-extends them first. A 16x16 signed multiplier holds its multiplicand in a T register and writes its 32-bit result to a P register. A separate transfer moves that product into the accumulator.

Results leave through a store path. The store path shifts the accumulator left by 0 to 7 places and returns either the low or the high half-word. The accumulator itself is not changed by a store, so a Q15 product can be stored as its high half-word with a shift of one. An operation-select port takes the place of an instruction decoder. Each operation takes effect on one clock edge.

Top module: `fxacc_core`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the accumulator, T, P, the carry and overflow flags and `storeWord`.
- R2: Load (op 1) writes the operand into the accumulator after a left shift by `shamt`; shift amounts above 16 act as 16. With `sxMode`=1 the operand is sign-extended before the shift; with `sxMode`=0 it is zero-extended, so an unshifted load clears bits 31..16.
- R3: Add (op 2), subtract (op 3) and add-with-carry (op 6) combine the accumulator with the shifted, extended operand. Add-with-carry also adds the current carry. Carry becomes bit 32 of the 33-bit unsigned result; for subtract, carry is 1 when no borrow occurs.
- R4: Every add or subtract operation (ops 2 to 6) sets the overflow flag when the signed 32-bit result is out of range and clears it otherwise.
- R5: Unsigned add (op 4) and unsigned subtract (op 5) use the operand zero-extended into bits 15..0, with no shift, whatever `shamt` and `sxMode` are. They update carry as in R3.
- R6: AND (op 7), OR (op 8) and XOR (op 9) combine the accumulator with the shifted, extended operand. They leave carry and overflow unchanged.
- R7: Load-T (op 10) writes the operand into T. Multiply (op 11) writes the signed product of T and the operand into P. Product transfer (op 12) copies P into the accumulator. None of the three changes carry or overflow.
- R8: Store-low (op 13) and store-high (op 14) set `storeWord` on the same edge. It takes bits 15..0 or bits 31..16 of the accumulator shifted left by `shamt[2:0]`. The accumulator is unchanged.
- R9: `storeWord` holds its value through every operation other than a store.
- R10: Shift-left (op 15) moves the accumulator one place left and puts the old bit 31 in carry. Shift-right (op 16) moves it one place right, copying bit 31 when `sxMode`=1 and inserting 0 when `sxMode`=0, and puts the old bit 0 in carry.
- R11: Rotate-left (op 17) and rotate-right (op 18) rotate the 33-bit value {carry, accumulator} by one place.
- R12: `accZero` is 1 exactly when the accumulator is zero, and `accNeg` equals accumulator bit 31.
- R13: No-op (op 0) and the unused codes 19 to 31 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 5 | Operation select |
| opnd | input | 16 | Data operand |
| shamt | input | 5 | Input shift (0 to 16), or output shift in bits 2..0 for stores |
| sxMode | input | 1 | 1 selects sign extension, 0 selects zero extension |
| storeWord | output | 16 | Shifted half-word from the last store |
| carryFlag | output | 1 | Carry flag |
| ovfFlag | output | 1 | Signed overflow flag |
| accZero | output | 1 | Accumulator equals zero |
| accNeg | output | 1 | Accumulator bit 31 |

## Verification
Loads are tried with negative and positive operands under both extension modes, and with shifts of 0, 4 and over 16. These cases tell sign extension from zero extension and show whether the shift clamps. The add and subtract paths are driven across the 32-bit signed boundary in both directions and through an unsigned wrap followed by add-with-carry. These cases separate carry from overflow and show whether the carry is propagated. Q15 products of positive and negative fractions are stored with an output shift of one and then re-stored with no shift. This shows that the output shift never reaches the accumulator. Shifts and rotates alternate with stores so that each bit moved in or out through carry is visible.

// File: rtl/fxacc_pkg.sv
package fxacc_pkg;
  parameter int DATA_W = 16;
  parameter int ACC_W  = 2 * DATA_W;
  parameter int ISH_W  = 5;
  parameter int OSH_W  = 3;
  parameter int OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 5'd0,  OP_LOAD = 5'd1,  OP_ADD  = 5'd2,  OP_SUB  = 5'd3,
    OP_ADDU = 5'd4,  OP_SUBU = 5'd5,  OP_ADDC = 5'd6,  OP_AND  = 5'd7,
    OP_OR   = 5'd8,  OP_XOR  = 5'd9,  OP_LDT  = 5'd10, OP_MPY  = 5'd11,
    OP_PAC  = 5'd12, OP_STL  = 5'd13, OP_STH  = 5'd14, OP_SFL  = 5'd15,
    OP_SFR  = 5'd16, OP_ROL  = 5'd17, OP_ROR  = 5'd18
  } op_e;

  typedef enum logic [2:0] {
    SRC_OPND, SRC_SUM, SRC_LOGIC, SRC_PROD, SRC_SHIFT
  } accSrc_e;

  typedef enum logic [1:0] { LG_AND, LG_OR, LG_XOR } logicSel_e;
  typedef enum logic [1:0] { SH_LEFT, SH_RIGHT, SH_ROTL, SH_ROTR } shiftSel_e;

  typedef struct packed {
    logic      accWe;
    accSrc_e   accSrc;
    logic      arithWe;
    logic      subtract;
    logic      useCarry;
    logic      rawLow;
    logicSel_e logicSel;
    shiftSel_e shiftSel;
    logic      tWe;
    logic      pWe;
    logic      storeWe;
    logic      storeHigh;
  } strobe_t;
endpackage

// File: rtl/fxacc_inshift.sv
module fxacc_inshift #(
  parameter int DW = 16,
  parameter int SW = 5
) (
  input  logic [DW-1:0]   din,
  input  logic [SW-1:0]   shift,
  input  logic            signExt,
  input  logic            rawLow,
  output logic [2*DW-1:0] aligned
);
  localparam int AW = 2 * DW;
  logic [AW-1:0] extended;
  logic [SW-1:0] shiftEff;

  always_comb begin
    extended = signExt ? {{DW{din[DW-1]}}, din} : {{DW{1'b0}}, din};
    shiftEff = (shift > SW'(DW)) ? SW'(DW) : shift;
    if (rawLow) aligned = {{DW{1'b0}}, din};
    else        aligned = extended << shiftEff;
  end
endmodule

// File: rtl/fxacc_ctrl.sv
module fxacc_ctrl
  import fxacc_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output strobe_t         strobe
);
  always_comb begin
    strobe = '0;
    strobe.accSrc   = SRC_OPND;
    strobe.logicSel = LG_AND;
    strobe.shiftSel = SH_LEFT;
    case (op_e'(op))
      OP_LOAD: strobe.accWe = 1'b1;
      OP_ADD, OP_SUB, OP_ADDU, OP_SUBU, OP_ADDC: begin
        strobe.accWe    = 1'b1;
        strobe.accSrc   = SRC_SUM;
        strobe.arithWe  = 1'b1;
        strobe.subtract = (op_e'(op) == OP_SUB) || (op_e'(op) == OP_SUBU);
        strobe.useCarry = (op_e'(op) == OP_ADDC);
        strobe.rawLow   = (op_e'(op) == OP_ADDU) || (op_e'(op) == OP_SUBU);
      end
      OP_AND, OP_OR, OP_XOR: begin
        strobe.accWe    = 1'b1;
        strobe.accSrc   = SRC_LOGIC;
        strobe.logicSel = (op_e'(op) == OP_AND) ? LG_AND :
                          (op_e'(op) == OP_OR)  ? LG_OR : LG_XOR;
      end
      OP_LDT: strobe.tWe = 1'b1;
      OP_MPY: strobe.pWe = 1'b1;
      OP_PAC: begin
        strobe.accWe  = 1'b1;
        strobe.accSrc = SRC_PROD;
      end
      OP_STL, OP_STH: begin
        strobe.storeWe   = 1'b1;
        strobe.storeHigh = (op_e'(op) == OP_STH);
      end
      OP_SFL, OP_SFR, OP_ROL, OP_ROR: begin
        strobe.accWe    = 1'b1;
        strobe.accSrc   = SRC_SHIFT;
        strobe.shiftSel = (op_e'(op) == OP_SFL) ? SH_LEFT :
                          (op_e'(op) == OP_SFR) ? SH_RIGHT :
                          (op_e'(op) == OP_ROL) ? SH_ROTL : SH_ROTR;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fxacc_dp.sv
module fxacc_dp
  import fxacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] opnd,
  input  logic [ISH_W-1:0]  shamt,
  input  logic              sxMode,
  output logic [DATA_W-1:0] storeWord,
  output logic              carryFlag,
  output logic              ovfFlag,
  output logic              accZero,
  output logic              accNeg
);
  logic [ACC_W-1:0]  acc, pReg, aluB, addIn, logicRes, shiftRes, accNext, outShifted;
  logic [DATA_W-1:0] tReg;
  logic [ACC_W:0]    sum;
  logic              cin, sumOvf, shiftCarry;
  logic [ACC_W-1:0]  prodFull;

  fxacc_inshift #(.DW(DATA_W), .SW(ISH_W)) u_inshift (
    .din(opnd), .shift(shamt), .signExt(sxMode),
    .rawLow(strobe.rawLow), .aligned(aluB)
  );

  always_comb begin
    addIn  = strobe.subtract ? ~aluB : aluB;
    cin    = strobe.subtract | (strobe.useCarry & carryFlag);
    sum    = {1'b0, acc} + {1'b0, addIn} + {{ACC_W{1'b0}}, cin};
    sumOvf = (acc[ACC_W-1] == addIn[ACC_W-1]) && (sum[ACC_W-1] != acc[ACC_W-1]);
  end

  always_comb begin
    case (strobe.logicSel)
      LG_AND:  logicRes = acc & aluB;
      LG_OR:   logicRes = acc | aluB;
      default: logicRes = acc ^ aluB;
    endcase
  end

  always_comb begin
    case (strobe.shiftSel)
      SH_LEFT: begin
        shiftRes   = {acc[ACC_W-2:0], 1'b0};
        shiftCarry = acc[ACC_W-1];
      end
      SH_RIGHT: begin
        shiftRes   = {sxMode & acc[ACC_W-1], acc[ACC_W-1:1]};
        shiftCarry = acc[0];
      end
      SH_ROTL: begin
        shiftRes   = {acc[ACC_W-2:0], carryFlag};
        shiftCarry = acc[ACC_W-1];
      end
      default: begin
        shiftRes   = {carryFlag, acc[ACC_W-1:1]};
        shiftCarry = acc[0];
      end
    endcase
  end

  always_comb begin
    case (strobe.accSrc)
      SRC_SUM:   accNext = sum[ACC_W-1:0];
      SRC_LOGIC: accNext = logicRes;
      SRC_PROD:  accNext = pReg;
      SRC_SHIFT: accNext = shiftRes;
      default:   accNext = aluB;
    endcase
  end

  assign prodFull   = $signed({{DATA_W{tReg[DATA_W-1]}}, tReg}) *
                      $signed({{DATA_W{opnd[DATA_W-1]}}, opnd});
  assign outShifted = acc << shamt[OSH_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      tReg      <= '0;
      pReg      <= '0;
      carryFlag <= 1'b0;
      ovfFlag   <= 1'b0;
      storeWord <= '0;
    end else begin
      if (strobe.accWe) acc <= accNext;
      if (strobe.tWe)   tReg <= opnd;
      if (strobe.pWe)   pReg <= prodFull;
      if (strobe.arithWe) begin
        carryFlag <= sum[ACC_W];
        ovfFlag   <= sumOvf;
      end else if (strobe.accWe && strobe.accSrc == SRC_SHIFT) begin
        carryFlag <= shiftCarry;
      end
      if (strobe.storeWe)
        storeWord <= strobe.storeHigh ? outShifted[ACC_W-1:DATA_W]
                                      : outShifted[DATA_W-1:0];
    end
  end

  assign accZero = (acc == '0);
  assign accNeg  = acc[ACC_W-1];
endmodule

// File: rtl/fxacc_core.sv
module fxacc_core
  import fxacc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] opnd,
  input  logic [ISH_W-1:0]  shamt,
  input  logic              sxMode,
  output logic [DATA_W-1:0] storeWord,
  output logic              carryFlag,
  output logic              ovfFlag,
  output logic              accZero,
  output logic              accNeg
);
  strobe_t strobe;

  fxacc_ctrl u_ctrl (.op(op), .strobe(strobe));

  fxacc_dp u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .opnd(opnd), .shamt(shamt),
    .sxMode(sxMode), .storeWord(storeWord), .carryFlag(carryFlag),
    .ovfFlag(ovfFlag), .accZero(accZero), .accNeg(accNeg)
  );
endmodule

// File: rtl/fxacc_chk.sv
module fxacc_chk
  import fxacc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op,
  input logic [DATA_W-1:0] storeWord,
  input logic              carryFlag,
  input logic              ovfFlag,
  input logic              accZero,
  input logic              accNeg
);
  logic isStore, isLogic, isMul, isIdle;
  assign isStore = (op == OP_STL) || (op == OP_STH);
  assign isLogic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign isMul   = (op == OP_LDT) || (op == OP_MPY);
  assign isIdle  = (op == OP_NOP) || (op > OP_ROR);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!carryFlag && !ovfFlag && accZero && storeWord == '0));

  assert_logic_keeps_flags_R6: assert property (@(posedge clk) disable iff (rst)
    isLogic |=> ($stable(carryFlag) && $stable(ovfFlag)));

  assert_mult_keeps_state_R7: assert property (@(posedge clk) disable iff (rst)
    isMul |=> ($stable(carryFlag) && $stable(ovfFlag) && $stable(accZero) && $stable(accNeg)));

  assert_store_keeps_acc_R8: assert property (@(posedge clk) disable iff (rst)
    isStore |=> ($stable(accZero) && $stable(accNeg) && $stable(carryFlag)));

  assert_store_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !isStore |=> $stable(storeWord));

  assert_idle_no_change_R13: assert property (@(posedge clk) disable iff (rst)
    isIdle |=> ($stable(carryFlag) && $stable(ovfFlag) && $stable(accZero) && $stable(storeWord)));
endmodule

bind fxacc_core fxacc_chk u_chk (
  .clk(clk), .rst(rst), .op(op), .storeWord(storeWord), .carryFlag(carryFlag),
  .ovfFlag(ovfFlag), .accZero(accZero), .accNeg(accNeg)
);

// File: tb/sim_fxacc_core.sv
module sim_fxacc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op = '0;
  logic [15:0] opnd = '0;
  logic [4:0]  shamt = '0;
  logic        sxMode = 1'b0;
  logic [15:0] storeWord;
  logic        carryFlag, ovfFlag, accZero, accNeg;

  int testsRun = 0;
  int testsFailed = 0;

  logic [31:0] mAcc, mP;
  logic [15:0] mT, mStore;
  logic        mC, mV;

  fxacc_core u0 (.*);

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic modelStep(input logic [4:0] o, input logic [15:0] d,
                           input logic [4:0] sh, input logic sx);
    logic [31:0] ext, b, bb, tmp;
    logic [32:0] r;
    int s;
    ext = sx ? {{16{d[15]}}, d} : {16'h0, d};
    s = (sh > 16) ? 16 : int'(sh);
    b = ext << s;
    case (o)
      5'd1: mAcc = b;
      5'd2, 5'd3, 5'd4, 5'd5, 5'd6: begin
        bb = (o == 5'd4 || o == 5'd5) ? {16'h0, d} : b;
        if (o == 5'd3 || o == 5'd5) begin
          r  = {1'b0, mAcc} - {1'b0, bb};
          mV = (mAcc[31] != bb[31]) && (r[31] != mAcc[31]);
          r[32] = ~r[32];
        end else begin
          r  = {1'b0, mAcc} + {1'b0, bb} + {32'h0, (o == 5'd6) ? mC : 1'b0};
          mV = (mAcc[31] == bb[31]) && (r[31] != mAcc[31]);
        end
        mAcc = r[31:0];
        mC   = r[32];
      end
      5'd7:  mAcc = mAcc & b;
      5'd8:  mAcc = mAcc | b;
      5'd9:  mAcc = mAcc ^ b;
      5'd10: mT = d;
      5'd11: mP = 32'($signed({{16{mT[15]}}, mT}) * $signed({{16{d[15]}}, d}));
      5'd12: mAcc = mP;
      5'd13, 5'd14: begin
        tmp = mAcc << sh[2:0];
        mStore = (o == 5'd14) ? tmp[31:16] : tmp[15:0];
      end
      5'd15: {mC, mAcc} = {mAcc, 1'b0};
      5'd16: begin
        mC   = mAcc[0];
        mAcc = {sx & mAcc[31], mAcc[31:1]};
      end
      5'd17: {mC, mAcc} = {mAcc, mC};
      5'd18: {mAcc, mC} = {mC, mAcc};
      default: ;
    endcase
  endtask

  task automatic doOp(input logic [4:0] o, input logic [15:0] d,
                      input logic [4:0] sh, input logic sx);
    @(negedge clk);
    op = o; opnd = d; shamt = sh; sxMode = sx;
    @(posedge clk);
    #1;
    modelStep(o, d, sh, sx);
  endtask

  task automatic checkState(input string tag);
    doOp(5'd13, 16'h0, 5'd0, 1'b0);
    chk({tag, " low word"}, {16'h0, storeWord}, {16'h0, mAcc[15:0]});
    doOp(5'd14, 16'h0, 5'd0, 1'b0);
    chk({tag, " high word"}, {16'h0, storeWord}, {16'h0, mAcc[31:16]});
    chk({tag, " carry"}, {31'h0, carryFlag}, {31'h0, mC});
    chk({tag, " overflow"}, {31'h0, ovfFlag}, {31'h0, mV});
    chk({tag, " zero R12"}, {31'h0, accZero}, {31'h0, (mAcc == 0)});
    chk({tag, " neg R12"}, {31'h0, accNeg}, {31'h0, mAcc[31]});
  endtask

  task automatic testReset();
    mAcc = 0; mP = 0; mT = 0; mC = 0; mV = 0; mStore = 0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 store word", {16'h0, storeWord}, 32'h0);
    chk("R1 carry", {31'h0, carryFlag}, 32'h0);
    chk("R1 overflow", {31'h0, ovfFlag}, 32'h0);
    chk("R1 zero", {31'h0, accZero}, 32'h1);
    @(negedge clk);
    rst = 1'b0;
    checkState("R1 state");
  endtask

  task automatic testLoad();
    doOp(5'd1, 16'h8001, 5'd4, 1'b1);
    doOp(5'd14, 16'h0, 5'd0, 1'b0);
    chk("R2 sign-extended load high", {16'h0, storeWord}, 32'h0000FFF8);
    doOp(5'd1, 16'h8001, 5'd4, 1'b0);
    checkState("R2 zero-extended load");
    doOp(5'd1, 16'h1234, 5'd20, 1'b1);
    doOp(5'd14, 16'h0, 5'd0, 1'b0);
    chk("R2 clamped shift high", {16'h0, storeWord}, 32'h00001234);
    doOp(5'd1, 16'hABCD, 5'd0, 1'b0);
    checkState("R2 unshifted load clears high");
  endtask

  task automatic testArith();
    doOp(5'd1, 16'h7FFF, 5'd16, 1'b1);
    doOp(5'd2, 16'h0001, 5'd16, 1'b1);
    checkState("R4 positive overflow");
    chk("R4 overflow set", {31'h0, ovfFlag}, 32'h1);
    doOp(5'd2, 16'h0000, 5'd0, 1'b1);
    checkState("R4 overflow cleared");
    doOp(5'd3, 16'h0001, 5'd0, 1'b1);
    checkState("R3 R4 subtract across boundary");
    doOp(5'd3, 16'hFFFF, 5'd3, 1'b1);
    checkState("R3 subtract negative shifted");
  endtask

  task automatic testUnsigned();
    doOp(5'd1, 16'hFFFF, 5'd0, 1'b1);
    doOp(5'd4, 16'h0001, 5'd9, 1'b1);
    checkState("R5 unsigned wrap");
    chk("R5 carry out", {31'h0, carryFlag}, 32'h1);
    doOp(5'd6, 16'h0000, 5'd0, 1'b0);
    checkState("R3 add with carry");
    doOp(5'd4, 16'h8000, 5'd4, 1'b1);
    checkState("R5 shift and sign ignored");
    doOp(5'd5, 16'h8001, 5'd3, 1'b1);
    checkState("R5 unsigned subtract");
  endtask

  task automatic testLogic();
    doOp(5'd1, 16'hFFFF, 5'd0, 1'b1);
    doOp(5'd4, 16'h0001, 5'd0, 1'b0);
    doOp(5'd1, 16'hF0F0, 5'd0, 1'b0);
    doOp(5'd7, 16'hFF00, 5'd0, 1'b0);
    checkState("R6 and");
    doOp(5'd8, 16'h000F, 5'd16, 1'b0);
    checkState("R6 or shifted");
    doOp(5'd9, 16'hFFFF, 5'd0, 1'b1);
    checkState("R6 xor sign-extended");
  endtask

  task automatic testMult();
    doOp(5'd10, 16'h4000, 5'd0, 1'b0);
    doOp(5'd11, 16'h4000, 5'd0, 1'b0);
    doOp(5'd12, 16'h0000, 5'd0, 1'b0);
    doOp(5'd14, 16'h0000, 5'd1, 1'b0);
    chk("R7 R8 Q15 positive product", {16'h0, storeWord}, 32'h00002000);
    checkState("R7 product in acc");
    doOp(5'd10, 16'h8000, 5'd0, 1'b0);
    doOp(5'd11, 16'h4000, 5'd0, 1'b0);
    doOp(5'd12, 16'h0000, 5'd0, 1'b0);
    doOp(5'd14, 16'h0000, 5'd1, 1'b0);
    chk("R7 R8 Q15 negative product", {16'h0, storeWord}, 32'h0000C000);
    doOp(5'd10, 16'hFFFD, 5'd0, 1'b0);
    doOp(5'd11, 16'h0007, 5'd0, 1'b0);
    checkState("R7 multiply leaves acc");
    doOp(5'd12, 16'h0000, 5'd0, 1'b0);
    checkState("R7 signed product transfer");
  endtask

  task automatic testStore();
    doOp(5'd1, 16'h9ABC, 5'd8, 1'b1);
    doOp(5'd13, 16'h0, 5'd7, 1'b0);
    chk("R8 store low shift 7", {16'h0, storeWord}, {16'h0, mStore});
    doOp(5'd14, 16'h0, 5'd5, 1'b0);
    chk("R8 store high shift 5", {16'h0, storeWord}, {16'h0, mStore});
    doOp(5'd1, 16'h1111, 5'd0, 1'b0);
    chk("R9 store word held after load", {16'h0, storeWord}, {16'h0, mStore});
    doOp(5'd2, 16'h2222, 5'd2, 1'b0);
    chk("R9 store word held after add", {16'h0, storeWord}, {16'h0, mStore});
    doOp(5'd1, 16'h9ABC, 5'd8, 1'b1);
    doOp(5'd14, 16'h0, 5'd7, 1'b0);
    checkState("R8 accumulator unchanged by stores");
  endtask

  task automatic testShiftRot();
    doOp(5'd1, 16'h8001, 5'd15, 1'b1);
    doOp(5'd15, 16'h0, 5'd0, 1'b0);
    checkState("R10 shift left");
    doOp(5'd1, 16'h8003, 5'd16, 1'b1);
    doOp(5'd16, 16'h0, 5'd0, 1'b1);
    checkState("R10 arithmetic shift right");
    doOp(5'd16, 16'h0, 5'd0, 1'b0);
    checkState("R10 logical shift right");
    doOp(5'd1, 16'h8000, 5'd16, 1'b1);
    doOp(5'd17, 16'h0, 5'd0, 1'b0);
    checkState("R11 rotate left out");
    doOp(5'd17, 16'h0, 5'd0, 1'b0);
    checkState("R11 rotate left in");
    doOp(5'd1, 16'h0001, 5'd0, 1'b0);
    doOp(5'd18, 16'h0, 5'd0, 1'b0);
    checkState("R11 rotate right out");
    doOp(5'd18, 16'h0, 5'd0, 1'b0);
    checkState("R11 rotate right in");
  endtask

  task automatic testIdle();
    doOp(5'd1, 16'hC3A5, 5'd6, 1'b1);
    doOp(5'd14, 16'h0, 5'd0, 1'b0);
    doOp(5'd0, 16'hFFFF, 5'd3, 1'b1);
    chk("R13 nop keeps store", {16'h0, storeWord}, {16'h0, mStore});
    doOp(5'd25, 16'h1234, 5'd1, 1'b1);
    doOp(5'd31, 16'h5678, 5'd2, 1'b0);
    checkState("R13 unused codes");
  endtask

  initial begin
    #(4 * 100000);
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    testReset();
    testLoad();
    testArith();
    testUnsigned();
    testLogic();
    testMult();
    testStore();
    testShiftRot();
    testIdle();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule